// File: doc/BRIEF.md
# Multi-port issue queue selector

This block is the scheduling window between dispatch and the execution ports of an out-of-order core. Up to `NINS` micro-ops enter per cycle, each carrying a sequence number, an operation class and `IQ_NSRC` source tags. For each source the dispatcher also passes two ready hints: the committed scoreboard and the speculative early scoreboard. Sources that are not ready at entry wait in a tag-match array. Broadcast wakeup tags set their ready bits.

Every cycle each issue port takes the ready entry with the smallest sequence number. The choice is held in a select register for one cycle, and in that next cycle the op is presented on the port. If the port reports itself busy, or the op is cancelled while it sits in the select register, the op is not presented. Instead it goes back into the ready pool for a later pick. The parameter `PORT_MASKS` lists the op classes each port accepts. When every port has the same mask, all ports draw from one shared pool. Otherwise each port considers only entries whose class its mask enables. A squash with a boundary sequence number removes all younger entries.

Top module: `iss_queue`

## Requirements
- R1: After reset no issue port is valid and `full_o` is low while no op is presented.
- R2: Among eligible entries, port 0 issues the one with the smallest sequence number and port 1 the next smallest. Two ports never issue the same entry in one cycle. An op whose sources are all ready when it is inserted at clock edge E is latched by the select stage at edge E+1 and is valid on its port between edges E+1 and E+2.
- R3: At insertion, a source counts as ready if its committed hint or its speculative hint is 1.
- R4: A wakeup tag that matches a waiting source makes the entry eligible in the cycle of the broadcast. This also holds for an op inserted in that same cycle. The op appears on a port in the cycle after the next edge.
- R5: While `port_busy_i[p]` is high, port p presents nothing. The op it had selected stays in the queue and issues once the port is free.
- R6: While `cancel_i[p]` is high, the op selected for port p is not presented. It stays in the queue and issues later.
- R7: A squash with boundary S removes every entry whose sequence number is greater than S and keeps all the others. No op is accepted in a squash cycle.
- R8: `full_o` is high exactly when fewer entries are free than the number of ops presented on `ins_valid_i`. While it is high, no presented op is accepted.
- R9: Bit `p*4+c` of `PORT_MASKS` enables class c (the 2-bit `ins_cls_i` field) on port p. When the port masks differ, a port only issues classes its mask enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ins_valid_i | input | NINS | Op present on each insert slot |
| ins_seq_i | input | NINS*8 | Sequence number per slot |
| ins_cls_i | input | NINS*2 | Operation class per slot |
| ins_tag_i | input | NINS*2*6 | Source tags, slot k source s at bits (k*2+s)*6 |
| ins_sb_rdy_i | input | NINS*2 | Committed-scoreboard ready hint per source |
| ins_spec_rdy_i | input | NINS*2 | Speculative-scoreboard ready hint per source |
| full_o | output | 1 | Presented ops do not fit; none accepted |
| wake_valid_i | input | NWAKE | Wakeup broadcast valid |
| wake_tag_i | input | NWAKE*6 | Wakeup tags |
| port_busy_i | input | NPORT | Execution port cannot take an op this cycle |
| cancel_i | input | NPORT | Selected op for the port is cancelled |
| iss_valid_o | output | NPORT | Op issued on the port |
| iss_seq_o | output | NPORT*8 | Sequence number of the issued op |
| iss_cls_o | output | NPORT*2 | Class of the issued op |
| squash_i | input | 1 | Remove younger entries |
| squash_seq_i | input | 8 | Squash boundary sequence number |

## Verification
The checks rely on several properties of the input stream. Sequence numbers are unique among live entries and never wrap inside the window, because the age and squash comparisons are plain unsigned compares. The dispatcher does not present ops in a squash cycle expecting them to be kept. The stimulus respects this: every sequence number it uses is distinct and below 256. Every squash is sent on a cycle with no insert. Busy and cancel are raised only for port 0, while the selected op is held in the select register.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int IQ_SEQ_W = 8;
    localparam int IQ_TAG_W = 6;
    localparam int IQ_CLS_W = 2;
    localparam int IQ_NSRC  = 2;
    localparam int IQ_NCLS  = 1 << IQ_CLS_W;

    typedef logic [IQ_SEQ_W-1:0] seq_t;
    typedef logic [IQ_TAG_W-1:0] tag_t;
    typedef logic [IQ_CLS_W-1:0] cls_t;

    typedef struct packed {
        logic                    vld;
        logic                    infl;
        seq_t                    seq;
        cls_t                    cls;
        tag_t [IQ_NSRC-1:0]      tag;
        logic [IQ_NSRC-1:0]      rdy;
    } iq_entry_t;
endpackage

// File: rtl/iq_free_finder.sv
module iq_free_finder #(
    parameter int DEPTH = 24,
    parameter int NSLOT = 2,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            used_i,
    output logic [NSLOT-1:0]            found_o,
    output logic [NSLOT-1:0][IDX_W-1:0] idx_o
);
    logic [DEPTH-1:0] avail;

    always_comb begin
        avail   = ~used_i;
        found_o = '0;
        idx_o   = '0;
        for (int k = 0; k < NSLOT; k++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (avail[i] && !found_o[k]) begin
                    found_o[k] = 1'b1;
                    idx_o[k]   = IDX_W'(i);
                end
            end
            if (found_o[k]) begin
                avail[idx_o[k]] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/iq_age_picker.sv
module iq_age_picker #(
    parameter int DEPTH = 24,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int SEQ_W = 8
) (
    input  logic [DEPTH-1:0]            elig_i,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
    output logic                        found_o,
    output logic [IDX_W-1:0]            idx_o
);
    logic [SEQ_W-1:0] best;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (elig_i[i] && (!found_o || seq_i[i] < best)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                best    = seq_i[i];
            end
        end
    end
endmodule

// File: rtl/iss_queue.sv
module iss_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int NINS  = 2,
    parameter int NPORT = 2,
    parameter int NWAKE = 2,
    parameter logic [NPORT*IQ_NCLS-1:0] PORT_MASKS = '1
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [NINS-1:0]                 ins_valid_i,
    input  logic [NINS*IQ_SEQ_W-1:0]        ins_seq_i,
    input  logic [NINS*IQ_CLS_W-1:0]        ins_cls_i,
    input  logic [NINS*IQ_NSRC*IQ_TAG_W-1:0] ins_tag_i,
    input  logic [NINS*IQ_NSRC-1:0]         ins_sb_rdy_i,
    input  logic [NINS*IQ_NSRC-1:0]         ins_spec_rdy_i,
    output logic                            full_o,
    input  logic [NWAKE-1:0]                wake_valid_i,
    input  logic [NWAKE*IQ_TAG_W-1:0]       wake_tag_i,
    input  logic [NPORT-1:0]                port_busy_i,
    input  logic [NPORT-1:0]                cancel_i,
    output logic [NPORT-1:0]                iss_valid_o,
    output logic [NPORT*IQ_SEQ_W-1:0]       iss_seq_o,
    output logic [NPORT*IQ_CLS_W-1:0]       iss_cls_o,
    input  logic                            squash_i,
    input  logic [IQ_SEQ_W-1:0]             squash_seq_i
);
    localparam int IDX_W = $clog2(DEPTH);

    function automatic bit masks_same();
        bit same = 1'b1;
        for (int p = 1; p < NPORT; p++) begin
            if (PORT_MASKS[p*IQ_NCLS +: IQ_NCLS] != PORT_MASKS[0 +: IQ_NCLS]) same = 1'b0;
        end
        return same;
    endfunction

    localparam bit SHARED = masks_same();

    typedef struct packed {
        iq_entry_t [DEPTH-1:0]          ent;
        logic [NPORT-1:0]               pick_v;
        logic [NPORT-1:0][IDX_W-1:0]    pick_idx;
    } state_t;

    state_t q_q, q_d;

    logic [DEPTH-1:0]                 vld_vec;
    logic [DEPTH-1:0]                 kill_vec;
    logic [DEPTH-1:0]                 base_elig;
    logic [DEPTH-1:0][IQ_NSRC-1:0]    rdy_eff;
    logic [DEPTH-1:0][IQ_SEQ_W-1:0]   seq_vec;
    logic [NINS-1:0]                  free_f;
    logic [NINS-1:0][IDX_W-1:0]       free_i;
    logic [NPORT-1:0]                 pick_f;
    logic [NPORT-1:0][IDX_W-1:0]      pick_i;
    logic [NPORT-1:0][DEPTH-1:0]      excl;
    logic [NPORT-1:0][DEPTH-1:0]      cand;

    // Per-entry readiness including this cycle's wakeups
    always_comb begin : ready_calc
        for (int i = 0; i < DEPTH; i++) begin
            vld_vec[i]  = q_q.ent[i].vld;
            seq_vec[i]  = q_q.ent[i].seq;
            kill_vec[i] = squash_i && (q_q.ent[i].seq > squash_seq_i);
            for (int s = 0; s < IQ_NSRC; s++) begin
                rdy_eff[i][s] = q_q.ent[i].rdy[s];
                for (int w = 0; w < NWAKE; w++) begin
                    if (wake_valid_i[w] &&
                        wake_tag_i[w*IQ_TAG_W +: IQ_TAG_W] == q_q.ent[i].tag[s]) begin
                        rdy_eff[i][s] = 1'b1;
                    end
                end
            end
            base_elig[i] = q_q.ent[i].vld && !q_q.ent[i].infl &&
                           (&rdy_eff[i]) && !kill_vec[i];
        end
    end

    iq_free_finder #(.DEPTH(DEPTH), .NSLOT(NINS), .IDX_W(IDX_W)) u_free (
        .used_i  (vld_vec),
        .found_o (free_f),
        .idx_o   (free_i)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        if (p == 0) begin : g_first
            assign excl[p] = '0;
        end else begin : g_rest
            assign excl[p] = excl[p-1] |
                             (pick_f[p-1] ? (DEPTH'(1) << pick_i[p-1]) : '0);
        end

        if (SHARED) begin : g_pool_shared
            assign cand[p] = base_elig & ~excl[p];
        end else begin : g_pool_split
            logic [DEPTH-1:0] cls_ok;
            for (genvar i = 0; i < DEPTH; i++) begin : g_cls
                assign cls_ok[i] = PORT_MASKS[p*IQ_NCLS + int'(q_q.ent[i].cls)];
            end
            assign cand[p] = base_elig & cls_ok & ~excl[p];
        end

        iq_age_picker #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SEQ_W(IQ_SEQ_W)) u_pick (
            .elig_i  (cand[p]),
            .seq_i   (seq_vec),
            .found_o (pick_f[p]),
            .idx_o   (pick_i[p])
        );
    end

    always_comb begin : next_state
        int unsigned nth;
        logic [IDX_W-1:0] slot;
        logic r;
        q_d         = q_q;
        iss_valid_o = '0;
        nth         = 0;
        slot        = '0;
        r           = 1'b0;
        full_o      = $countones(ins_valid_i) > (DEPTH - $countones(vld_vec));

        // issue stage: present or put back for retry
        for (int p = 0; p < NPORT; p++) begin
            iss_seq_o[p*IQ_SEQ_W +: IQ_SEQ_W] = q_q.ent[q_q.pick_idx[p]].seq;
            iss_cls_o[p*IQ_CLS_W +: IQ_CLS_W] = q_q.ent[q_q.pick_idx[p]].cls;
            if (q_q.pick_v[p]) begin
                if (!port_busy_i[p] && !cancel_i[p] && !kill_vec[q_q.pick_idx[p]]) begin
                    iss_valid_o[p]                 = 1'b1;
                    q_d.ent[q_q.pick_idx[p]].vld   = 1'b0;
                end
                q_d.ent[q_q.pick_idx[p]].infl = 1'b0;
            end
        end

        // wakeup and squash on stored entries
        for (int i = 0; i < DEPTH; i++) begin
            q_d.ent[i].rdy = rdy_eff[i];
            if (kill_vec[i]) begin
                q_d.ent[i].vld  = 1'b0;
                q_d.ent[i].infl = 1'b0;
            end
        end

        // select stage
        for (int p = 0; p < NPORT; p++) begin
            q_d.pick_v[p]   = pick_f[p];
            q_d.pick_idx[p] = pick_i[p];
            if (pick_f[p]) q_d.ent[pick_i[p]].infl = 1'b1;
        end

        // allocation
        if (!full_o && !squash_i) begin
            for (int k = 0; k < NINS; k++) begin
                if (ins_valid_i[k]) begin
                    if (free_f[nth]) begin
                        slot = free_i[nth];
                        q_d.ent[slot].vld  = 1'b1;
                        q_d.ent[slot].infl = 1'b0;
                        q_d.ent[slot].seq  = ins_seq_i[k*IQ_SEQ_W +: IQ_SEQ_W];
                        q_d.ent[slot].cls  = ins_cls_i[k*IQ_CLS_W +: IQ_CLS_W];
                        for (int s = 0; s < IQ_NSRC; s++) begin
                            q_d.ent[slot].tag[s] = ins_tag_i[(k*IQ_NSRC+s)*IQ_TAG_W +: IQ_TAG_W];
                            r = ins_sb_rdy_i[k*IQ_NSRC+s] | ins_spec_rdy_i[k*IQ_NSRC+s];
                            for (int w = 0; w < NWAKE; w++) begin
                                if (wake_valid_i[w] &&
                                    wake_tag_i[w*IQ_TAG_W +: IQ_TAG_W] ==
                                    ins_tag_i[(k*IQ_NSRC+s)*IQ_TAG_W +: IQ_TAG_W]) r = 1'b1;
                            end
                            q_d.ent[slot].rdy[s] = r;
                        end
                    end
                    nth = nth + 1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_d;
    end

    // R2
    if (NPORT > 1) begin : g_dup
        no_dup_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (iss_valid_o[0] && iss_valid_o[1]) |-> (q_q.pick_idx[0] != q_q.pick_idx[1]));
    end

    // R8
    full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full_o |=> ($countones(vld_vec) <= $past($countones(vld_vec))));

    for (genvar p = 0; p < NPORT; p++) begin : g_retry_chk
        // R5 and R6
        retry_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (q_q.pick_v[p] && (port_busy_i[p] || cancel_i[p]) && !squash_i)
            |=> vld_vec[$past(q_q.pick_idx[p])]);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_sq_chk
        // R7
        squash_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (squash_i && vld_vec[i] && (q_q.ent[i].seq > squash_seq_i)) |=> !vld_vec[i]);
    end
endmodule

// File: tb/iss_queue_tb_top.sv
`timescale 1ns/1ps
module iss_queue_tb_top;
    import iq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]  ins_valid;
    logic [15:0] ins_seq;
    logic [3:0]  ins_cls;
    logic [23:0] ins_tag;
    logic [3:0]  ins_sb, ins_sp;
    logic        full;
    logic [1:0]  wake_v;
    logic [11:0] wake_tag;
    logic [1:0]  busy, cancel;
    logic [1:0]  iss_v;
    logic [15:0] iss_seq;
    logic [3:0]  iss_cls;
    logic        squash;
    logic [7:0]  squash_seq;

    logic [1:0]  s_ins_valid;
    logic [15:0] s_ins_seq;
    logic [3:0]  s_ins_cls;
    logic        s_full;
    logic [1:0]  s_iss_v;
    logic [15:0] s_iss_seq;
    logic [3:0]  s_iss_cls;

    iss_queue dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ins_valid_i(ins_valid), .ins_seq_i(ins_seq), .ins_cls_i(ins_cls),
        .ins_tag_i(ins_tag), .ins_sb_rdy_i(ins_sb), .ins_spec_rdy_i(ins_sp),
        .full_o(full), .wake_valid_i(wake_v), .wake_tag_i(wake_tag),
        .port_busy_i(busy), .cancel_i(cancel),
        .iss_valid_o(iss_v), .iss_seq_o(iss_seq), .iss_cls_o(iss_cls),
        .squash_i(squash), .squash_seq_i(squash_seq)
    );

    iss_queue #(.PORT_MASKS(8'b0010_0001)) dut_split_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ins_valid_i(s_ins_valid), .ins_seq_i(s_ins_seq), .ins_cls_i(s_ins_cls),
        .ins_tag_i('0), .ins_sb_rdy_i(4'hF), .ins_spec_rdy_i(4'h0),
        .full_o(s_full), .wake_valid_i(2'b00), .wake_tag_i('0),
        .port_busy_i(2'b00), .cancel_i(2'b00),
        .iss_valid_o(s_iss_v), .iss_seq_o(s_iss_seq), .iss_cls_o(s_iss_cls),
        .squash_i(1'b0), .squash_seq_i(8'd0)
    );

    int n_checks = 0;
    int n_errors = 0;
    int exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic clr_in();
        ins_valid = '0; ins_seq = '0; ins_cls = '0; ins_tag = '0;
        ins_sb = '0; ins_sp = '0; wake_v = '0; wake_tag = '0;
        squash = 1'b0; squash_seq = '0;
        s_ins_valid = '0; s_ins_seq = '0; s_ins_cls = '0;
    endtask

    task automatic put(input int k, input int seq, input int cls,
                       input int t0, input bit sb0, input bit sp0,
                       input int t1, input bit sb1, input bit sp1);
        ins_valid[k]          = 1'b1;
        ins_seq[k*8 +: 8]     = 8'(seq);
        ins_cls[k*2 +: 2]     = 2'(cls);
        ins_tag[(k*2)*6 +: 6]   = 6'(t0);
        ins_tag[(k*2+1)*6 +: 6] = 6'(t1);
        ins_sb[k*2] = sb0; ins_sp[k*2] = sp0;
        ins_sb[k*2+1] = sb1; ins_sp[k*2+1] = sp1;
    endtask

    task automatic cyc();
        @(negedge clk);
        clr_in();
    endtask

    // scoreboard monitor: expected items are port*1000+seq in issue order
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (iss_v[p]) begin
                    int got;
                    got = p*1000 + int'(iss_seq[p*8 +: 8]);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected issue", got, -1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        check(got == e, "R2 issue order", got, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL R2 watchdog expired act=%0d exp=%0d", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        clr_in();
        busy = '0; cancel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(); #2;
        // R1 reset state
        check(iss_v == 2'b00, "R1 no issue after reset", int'(iss_v), 0);
        check(full == 1'b0, "R1 not full after reset", int'(full), 0);

        // R2 oldest first across ports, inserted in one cycle
        cyc(); put(0, 5, 0, 1, 1, 0, 2, 1, 0); put(1, 3, 0, 1, 1, 0, 2, 1, 0);
        exp_q.push_back(3); exp_q.push_back(1000 + 5);
        cyc(); #2;
        check(iss_v == 2'b00, "R2 not issued before select edge", int'(iss_v), 0);
        cyc(); #2;
        check(iss_v == 2'b11, "R2 both ports issue", int'(iss_v), 3);
        repeat (3) cyc();

        // R3 speculative hint counts as ready
        cyc(); put(0, 11, 1, 9, 0, 1, 8, 1, 0);
        exp_q.push_back(11);
        cyc();
        cyc(); #2;
        check(iss_v[0] && iss_seq[7:0] == 8'd11, "R3 spec-ready op issues", int'(iss_seq[7:0]), 11);
        repeat (2) cyc();

        // R4 wakeup during insertion cycle
        cyc(); put(0, 12, 1, 13, 0, 0, 8, 1, 0); wake_v[0] = 1'b1; wake_tag[5:0] = 6'd13;
        exp_q.push_back(12);
        cyc();
        cyc(); #2;
        check(iss_v[0] && iss_seq[7:0] == 8'd12, "R4 same-cycle wake at insert", int'(iss_seq[7:0]), 12);
        repeat (2) cyc();

        // R4 waiting source woken later
        cyc(); put(0, 10, 2, 7, 0, 0, 8, 1, 0);
        repeat (3) cyc();
        #2;
        check(iss_v == 2'b00, "R4 waits for tag", int'(iss_v), 0);
        cyc(); wake_v[1] = 1'b1; wake_tag[11:6] = 6'd7;
        exp_q.push_back(10);
        cyc(); #2;
        check(iss_v[0] && iss_seq[7:0] == 8'd10, "R4 issue after wake", int'(iss_seq[7:0]), 10);
        repeat (2) cyc();

        // R5 busy port holds the op
        cyc(); busy[0] = 1'b1; put(0, 20, 0, 1, 1, 0, 1, 1, 0);
        cyc();
        for (int c = 0; c < 4; c++) begin
            cyc(); #2;
            check(iss_v == 2'b00, "R5 busy port issues nothing", int'(iss_v), 0);
        end
        exp_q.push_back(20);
        cyc(); busy[0] = 1'b0;
        repeat (4) cyc();
        check(exp_q.size() == 0, "R5 held op issued after busy", exp_q.size(), 0);

        // R6 cancelled pick is retried
        cyc(); cancel[0] = 1'b1; put(0, 30, 3, 1, 1, 0, 1, 1, 0);
        cyc();
        for (int c = 0; c < 4; c++) begin
            cyc(); #2;
            check(iss_v == 2'b00, "R6 cancelled pick not issued", int'(iss_v), 0);
        end
        exp_q.push_back(30);
        cyc(); cancel[0] = 1'b0;
        repeat (4) cyc();
        check(exp_q.size() == 0, "R6 cancelled op issued later", exp_q.size(), 0);

        // R7 squash removes younger entries only
        cyc(); put(0, 40, 0, 50, 0, 0, 1, 1, 0); put(1, 41, 0, 50, 0, 0, 1, 1, 0);
        cyc(); put(0, 42, 0, 50, 0, 0, 1, 1, 0);
        cyc(); squash = 1'b1; squash_seq = 8'd40;
        cyc();
        cyc(); wake_v[0] = 1'b1; wake_tag[5:0] = 6'd50;
        exp_q.push_back(40);
        repeat (6) cyc();
        check(exp_q.size() == 0, "R7 older entry kept", exp_q.size(), 0);

        // R8 full when fewer free entries than presented ops
        for (int c = 0; c < 11; c++) begin
            cyc(); put(0, 100 + 2*c, 0, 60, 0, 0, 1, 1, 0); put(1, 101 + 2*c, 0, 60, 0, 0, 1, 1, 0);
        end
        cyc(); put(0, 122, 0, 60, 0, 0, 1, 1, 0);
        cyc(); put(0, 200, 0, 1, 1, 0, 1, 1, 0); put(1, 201, 0, 1, 1, 0, 1, 1, 0);
        #2; check(full == 1'b1, "R8 one free, two presented", int'(full), 1);
        cyc(); put(0, 123, 0, 60, 0, 0, 1, 1, 0);
        #2; check(full == 1'b0, "R8 one free, one presented", int'(full), 0);
        cyc(); put(0, 202, 0, 1, 1, 0, 1, 1, 0);
        #2; check(full == 1'b1, "R8 no free entry", int'(full), 1);
        cyc(); #2;
        check(full == 1'b0, "R8 nothing presented", int'(full), 0);
        cyc(); wake_v[0] = 1'b1; wake_tag[5:0] = 6'd60;
        for (int c = 0; c < 12; c++) begin
            exp_q.push_back(100 + 2*c);
            exp_q.push_back(1000 + 101 + 2*c);
        end
        repeat (20) cyc();
        check(exp_q.size() == 0, "R8 all accepted ops drained", exp_q.size(), 0);

        // R9 split pools by class mask
        cyc();
        s_ins_valid = 2'b11;
        s_ins_seq = {8'd5, 8'd3};
        s_ins_cls = {2'd0, 2'd1};
        cyc();
        cyc(); #2;
        check(s_iss_v == 2'b11, "R9 both split ports issue", int'(s_iss_v), 3);
        check(s_iss_seq[7:0] == 8'd5, "R9 port0 takes class0 op", int'(s_iss_seq[7:0]), 5);
        check(s_iss_cls[1:0] == 2'd0, "R9 port0 class", int'(s_iss_cls[1:0]), 0);
        check(s_iss_seq[15:8] == 8'd3, "R9 port1 takes class1 op", int'(s_iss_seq[15:8]), 3);

        repeat (3) cyc();
        check(exp_q.size() == 0, "R2 scoreboard empty at end", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule